// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This block sits between a word-addressed bus master and a single memory or peripheral slave and gives each bit of two 1MB address windows its own full word address. A data access that falls in one of two 32MB alias windows is redirected to one bit of one word in the 1MB window paired with it. A read through an alias hands back that single bit in bit 0. A write through an alias becomes a read of the target word followed by a write of the same word with only the chosen bit changed. All other traffic is passed to the slave as it arrives. Instruction fetches are always passed through, including fetches that land in an alias window.

The master offers one request at a time with a one-cycle `mReq` pulse while `mReady` is high. It then waits for the one-cycle `mDone` pulse. The slave side holds `sReq` and its fields steady until `sAck`, and read data returns with `sAck` in the same cycle. The master is locked out for the whole of a read-modify-write, so no other access can reach the target word between the slave read and the slave write.

Top module: `bitband_remap`

## Requirements
- R1: While reset is held and in the first cycle after it, `mReady` is 1, `sReq` is 0 and `mDone` is 0.
- R2: A data access whose address is outside both alias windows is issued to the slave once, with the same address, write enable and write data. A read returns the slave's word unchanged.
- R3: A data read in the low alias window (0x22000000 to 0x23FFFFFF) reads the slave word at 0x20000000 + (offset >> 7) * 4, where offset is the address minus 0x22000000. It returns bit ((offset >> 2) & 31) of that word in `mRdata[0]`, with `mRdata[31:1]` zero.
- R4: A data read in the high alias window (0x42000000 to 0x43FFFFFF) does the same against the word window at 0x40000000.
- R5: A data write in either alias window changes only the selected bit of the target word, setting it to `mWdata[0]`. The other 31 bits of the word and `mWdata[31:1]` have no effect on what is written.
- R6: An access with `mInstr` = 1 is never remapped, even inside an alias window. It reaches the slave at its own address.
- R7: `mReady` is low from the cycle after a request is accepted until the access completes. An `mReq` pulse while `mReady` is low is ignored and produces no slave traffic.
- R8: While `sReq` is high and `sAck` is low, `sAddr`, `sWe` and `sWdata` hold steady. `mDone` pulses for one cycle, in the cycle after the clock edge that samples the final `sAck`.
- R9: An alias write makes exactly two slave transactions: first a read (`sWe` = 0), then a write (`sWe` = 1) to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mReq | input | 1 | One-cycle request pulse from the master, taken only when `mReady` is high |
| mInstr | input | 1 | 1 marks an instruction fetch, which is never remapped |
| mWe | input | 1 | 1 for a write, 0 for a read |
| mAddr | input | 32 | Byte address of the word access |
| mWdata | input | 32 | Write data |
| mReady | output | 1 | High when a new request can be accepted |
| mDone | output | 1 | One-cycle completion pulse |
| mRdata | output | 32 | Read result, valid while `mDone` is high for reads |
| sReq | output | 1 | Slave request, held until acknowledged |
| sWe | output | 1 | Slave write enable |
| sAddr | output | 32 | Slave word address |
| sWdata | output | 32 | Slave write data |
| sAck | input | 1 | Slave acknowledge, one cycle |
| sRdata | input | 32 | Slave read data, valid with `sAck` |

## Verification
Each slave phase lasts the slave latency L plus two cycles: one for the acknowledge to be set and one for the remapper to sample it. A pass-through or alias read therefore shows `mDone` on the (L+3)th falling edge after the accepting edge, and an alias write shows it on the (2L+5)th. The bench counts falling edges from acceptance and compares that count with this formula while it sweeps L from 0 to 2. It samples `mRdata` and the slave memory only at the falling edge where `mDone` is seen. It also logs the order of read and write acknowledges, so that the read-then-write order of an alias write can be compared against the expected two-step sequence.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MODWR = 2'd2,
    ST_DONE  = 2'd3
  } bbState_t;

  typedef struct packed {
    logic capture;
    logic loadRd;
    logic writePhase;
  } bbStrobe_t;
endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mReq,
  input  logic      sAck,
  input  logic      isAlias,
  input  logic      isWrite,
  output logic      mReady,
  output logic      mDone,
  output logic      sReq,
  output bbStrobe_t strobe
);
  bbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (mReq) begin
          strobe.capture = 1'b1;
          stateNext      = ST_READ;
        end
      end
      ST_READ: begin
        if (sAck) begin
          strobe.loadRd = 1'b1;
          stateNext     = (isAlias && isWrite) ? ST_MODWR : ST_DONE;
        end
      end
      ST_MODWR: begin
        strobe.writePhase = 1'b1;
        if (sAck) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign mReady = (state == ST_IDLE);
  assign mDone  = (state == ST_DONE);
  assign sReq   = (state == ST_READ) || (state == ST_MODWR);
endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_WIN = 2,
  parameter int BAND_W = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = '0,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BAND_BASE  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mWdata,
  input  logic              mWe,
  input  logic              mInstr,
  input  logic [DATA_W-1:0] sRdata,
  output logic              isAlias,
  output logic              isWrite,
  output logic [ADDR_W-1:0] sAddr,
  output logic              sWe,
  output logic [DATA_W-1:0] sWdata,
  output logic [DATA_W-1:0] mRdata
);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int ALIAS_W = BAND_W + BIT_W;
  localparam int WORD_W  = BAND_W - BYTE_W;
  localparam int TOP_W   = ADDR_W - ALIAS_W;
  localparam int BTOP_W  = ADDR_W - BAND_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdQ;
  logic              weQ, instrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      weQ    <= 1'b0;
      instrQ <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= mAddr;
        wdataQ <= mWdata;
        weQ    <= mWe;
        instrQ <= mInstr;
      end
      if (strobe.loadRd) rdQ <= sRdata;
    end
  end

  logic [NUM_WIN-1:0] winHit;
  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    assign winHit[g] = (addrQ[ADDR_W-1:ALIAS_W] == ALIAS_BASE[g][ADDR_W-1:ALIAS_W]);
  end

  logic [BTOP_W-1:0] bandTop;
  always_comb begin
    bandTop = '0;
    for (int g = NUM_WIN - 1; g >= 0; g--) begin
      if (winHit[g]) bandTop = BAND_BASE[g][ADDR_W-1:BAND_W];
    end
  end

  logic [WORD_W-1:0] wordIdx;
  logic [BIT_W-1:0]  bitIdx;
  logic [ADDR_W-1:0] target;
  logic [DATA_W-1:0] merged;

  assign wordIdx = addrQ[ALIAS_W-1:BIT_W+BYTE_W];
  assign bitIdx  = addrQ[BIT_W+BYTE_W-1:BYTE_W];
  assign target  = {bandTop, wordIdx, {BYTE_W{1'b0}}};
  assign isAlias = (|winHit) && !instrQ;
  assign isWrite = weQ;

  always_comb begin
    merged         = rdQ;
    merged[bitIdx] = wdataQ[0];
  end

  assign sAddr  = isAlias ? target : addrQ;
  assign sWe    = strobe.writePhase ? 1'b1 : (isAlias ? 1'b0 : weQ);
  assign sWdata = strobe.writePhase ? merged : wdataQ;
  assign mRdata = isAlias ? {{(DATA_W-1){1'b0}}, rdQ[bitIdx]} : rdQ;

  logic unusedTop;
  assign unusedTop = ^{TOP_W{1'b0}};
endmodule

// File: rtl/bitband_remap.sv
module bitband_remap
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_WIN = 2,
  parameter int BAND_W = 20,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] BAND_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mReq,
  input  logic              mInstr,
  input  logic              mWe,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mWdata,
  output logic              mReady,
  output logic              mDone,
  output logic [DATA_W-1:0] mRdata,
  output logic              sReq,
  output logic              sWe,
  output logic [ADDR_W-1:0] sAddr,
  output logic [DATA_W-1:0] sWdata,
  input  logic              sAck,
  input  logic [DATA_W-1:0] sRdata
);
  bbStrobe_t strobe;
  logic      isAlias, isWrite;

  bb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mReq    (mReq),
    .sAck    (sAck),
    .isAlias (isAlias),
    .isWrite (isWrite),
    .mReady  (mReady),
    .mDone   (mDone),
    .sReq    (sReq),
    .strobe  (strobe)
  );

  bb_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_WIN    (NUM_WIN),
    .BAND_W     (BAND_W),
    .ALIAS_BASE (ALIAS_BASE),
    .BAND_BASE  (BAND_BASE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mAddr   (mAddr),
    .mWdata  (mWdata),
    .mWe     (mWe),
    .mInstr  (mInstr),
    .sRdata  (sRdata),
    .isAlias (isAlias),
    .isWrite (isWrite),
    .sAddr   (sAddr),
    .sWe     (sWe),
    .sWdata  (sWdata),
    .mRdata  (mRdata)
  );
endmodule

// File: rtl/bb_remap_checker.sv
module bb_remap_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              mReq,
  input logic              mReady,
  input logic              mDone,
  input logic              sReq,
  input logic              sAck,
  input logic              sWe,
  input logic [ADDR_W-1:0] sAddr,
  input logic [DATA_W-1:0] sWdata
);
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mReady) |=> !mReady);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    mReady |-> !sReq);

  assert_slave_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && !sAck) |=> (sReq && $stable(sAddr) && $stable(sWe) && $stable(sWdata)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    mDone |=> (!mDone && mReady));

  assert_write_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sReq && sAck && sWe) |=> (mDone && !sReq));
endmodule

bind bitband_remap bb_remap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mReq   (mReq),
  .mReady (mReady),
  .mDone  (mDone),
  .sReq   (sReq),
  .sAck   (sAck),
  .sWe    (sWe),
  .sAddr  (sAddr),
  .sWdata (sWdata)
);

// File: tb/sim_bitband_remap.sv
module sim_bitband_remap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mReq = 1'b0, mInstr = 1'b0, mWe = 1'b0;
  logic [31:0] mAddr = '0, mWdata = '0;
  logic        mReady, mDone, sReq, sWe;
  logic [31:0] mRdata, sAddr, sWdata;
  logic        sAck;
  logic [31:0] sRdata;

  bitband_remap u0 (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mInstr(mInstr), .mWe(mWe),
    .mAddr(mAddr), .mWdata(mWdata), .mReady(mReady), .mDone(mDone),
    .mRdata(mRdata), .sReq(sReq), .sWe(sWe), .sAddr(sAddr),
    .sWdata(sWdata), .sAck(sAck), .sRdata(sRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [logic [31:0]];
  int          slvLat = 0;
  int          rdCnt = 0, wrCnt = 0;
  logic [7:0]  opLog = '0;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  function automatic logic [31:0] memRd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // slave model: acknowledge after slvLat extra cycles
  initial begin
    int cnt;
    cnt = 0;
    sAck = 1'b0;
    sRdata = '0;
    forever begin
      @(posedge clk);
      if (sAck) begin
        sAck <= 1'b0;
        cnt = 0;
      end else if (sReq) begin
        if (cnt == slvLat) begin
          sAck <= 1'b1;
          if (sWe) begin
            mem[sAddr] = sWdata;
            wrCnt++;
          end else begin
            sRdata <= memRd(sAddr);
            rdCnt++;
          end
          opLog = {opLog[6:0], sWe};
        end else cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] wd, input bit we, input bit instr,
                        input bit intrude, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    mReq = 1'b1; mAddr = a; mWdata = wd; mWe = we; mInstr = instr;
    @(posedge clk);
    @(negedge clk);
    mReq = 1'b0;
    cyc = 1;
    while (!mDone) begin
      if (intrude && cyc == 2) begin
        mReq = 1'b1; mAddr = 32'h2000_0200; mWdata = 32'hDEAD_BEEF; mWe = 1'b1; mInstr = 1'b0;
      end else mReq = 1'b0;
      @(negedge clk);
      cyc++;
    end
    mReq = 1'b0;
    rd = mRdata;
  endtask

  task automatic sweepWindow(input logic [31:0] aBase, input logic [31:0] bBase, input string rRd);
    logic [31:0] rd, words [3], pat, aAddr, bAddr, wd;
    int cyc, r0, w0;
    logic [7:0] lg;
    words[0] = 32'h0; words[1] = 32'h1; words[2] = 32'h3FFFF;
    for (int w = 0; w < 3; w++) begin
      bAddr = bBase + words[w] * 4;
      pat = 32'h9E37_79B9 ^ (words[w] * 32'h0101_0101) ^ aBase;
      mem[bAddr] = pat;
      for (int b = 0; b < 32; b++) begin
        slvLat = b % 3;
        aAddr = aBase + words[w] * 128 + b * 4;
        access(aAddr, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, rd, cyc);
        check(rd == {31'b0, pat[b]}, rRd, rd, {31'b0, pat[b]});
        check(cyc == slvLat + 3, "R8 read done timing", cyc, slvLat + 3);
      end
      for (int b = 0; b < 32; b++) begin
        slvLat = (b + w) % 3;
        aAddr = aBase + words[w] * 128 + b * 4;
        wd = {31'h5AA5_5AA5 ^ b, ~pat[b]};
        r0 = rdCnt; w0 = wrCnt;
        access(aAddr, wd, 1'b1, 1'b0, 1'b0, rd, cyc);
        pat[b] = wd[0];
        check(memRd(bAddr) == pat, "R5 alias write merge", memRd(bAddr), pat);
        check(cyc == 2 * slvLat + 5, "R8 write done timing", cyc, 2 * slvLat + 5);
        lg = opLog;
        check(rdCnt - r0 == 1 && wrCnt - w0 == 1 && lg[1:0] == 2'b01,
              "R9 read then write", {24'h0, lg}, 32'h1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, r0, w0;
    repeat (3) @(negedge clk);
    check(mReady == 1'b1 && sReq == 1'b0 && mDone == 1'b0, "R1 in reset",
          {29'b0, mReady, sReq, mDone}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(mReady == 1'b1 && sReq == 1'b0 && mDone == 1'b0, "R1 after reset",
          {29'b0, mReady, sReq, mDone}, 32'h4);

    // R2 pass-through
    mem[32'h2000_0010] = 32'hA5A5_0F0F;
    slvLat = 1;
    r0 = rdCnt;
    access(32'h2000_0010, 32'h0, 1'b0, 1'b0, 1'b0, rd, cyc);
    check(rd == 32'hA5A5_0F0F, "R2 direct read", rd, 32'hA5A5_0F0F);
    check(rdCnt - r0 == 1, "R2 one slave read", rdCnt - r0, 1);
    w0 = wrCnt;
    access(32'h2000_0010, 32'h1234_5678, 1'b1, 1'b0, 1'b0, rd, cyc);
    check(memRd(32'h2000_0010) == 32'h1234_5678, "R2 direct write",
          memRd(32'h2000_0010), 32'h1234_5678);
    check(wrCnt - w0 == 1 && cyc == slvLat + 3, "R2 single write phase", cyc, slvLat + 3);
    mem[32'h6000_0004] = 32'h0BAD_CAFE;
    access(32'h6000_0004, 32'h0, 1'b0, 1'b0, 1'b0, rd, cyc);
    check(rd == 32'h0BAD_CAFE, "R2 unrelated address", rd, 32'h0BAD_CAFE);

    // R6 instruction fetch is never remapped
    mem[32'h2200_0084] = 32'hCAFE_F00D;
    access(32'h2200_0084, 32'h0, 1'b0, 1'b1, 1'b0, rd, cyc);
    check(rd == 32'hCAFE_F00D, "R6 fetch not remapped", rd, 32'hCAFE_F00D);
    mem[32'h4200_0100] = 32'h7777_0001;
    access(32'h4200_0100, 32'h0, 1'b0, 1'b1, 1'b0, rd, cyc);
    check(rd == 32'h7777_0001, "R6 fetch high window", rd, 32'h7777_0001);

    sweepWindow(32'h2200_0000, 32'h2000_0000, "R3 low alias read");
    sweepWindow(32'h4200_0000, 32'h4000_0000, "R4 high alias read");

    // R7 intruding request during an alias write is ignored
    mem[32'h2000_0200] = 32'h1111_1111;
    mem[32'h2000_0040] = 32'h0;
    slvLat = 3;
    w0 = wrCnt;
    access(32'h2200_0800 + 5 * 4, 32'h1, 1'b1, 1'b0, 1'b1, rd, cyc);
    check(memRd(32'h2000_0200) == 32'h1111_1111, "R7 busy request ignored",
          memRd(32'h2000_0200), 32'h1111_1111);
    check(memRd(32'h2000_0040) == 32'h20, "R7 alias write intact",
          memRd(32'h2000_0040), 32'h20);
    repeat (3) @(negedge clk);
    check(wrCnt - w0 == 1 && mReady, "R7 no extra slave traffic", wrCnt - w0, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule